// File: doc/BRIEF.md
# Read-to-Clear Interrupt Status Register

This block collects single-cycle event pulses from a touch-sensing engine (touch seen, new coordinate data, pen lifted, conversion fault) and from three general port activity sources. It holds them as sticky bits in one 8-bit status register. A host reads that register over a simple strobe-and-address register bus. The block drives a level interrupt line that is qualified by a separate 8-bit enable register.

A read never drops an event. The strobe copies the current status into a snapshot, and the clear that follows removes only the bits in that copy. A pulse that lands while the read is under way therefore stays pending for the next read. Some bits do not clear on a status read, depending on the operating mode. The coordinate-data bit waits for the host to fetch the data in the timer and host-paced modes. The touch bit is held while the pen is down in the pen-down mode, and the interrupt line is silenced in that mode.

Top module: `irq_status_reg`

## Requirements
- R1: After reset the status register, the enable register, `rd_data` and `irq` are all zero.
- R2: Status bit positions are: bit 7 fault, bit 6 pen lifted, bit 5 port 2, bit 3 port 1, bit 2 port 0, bit 1 data ready, bit 0 touch. Bit 4 always reads 0.
- R3: An event pulse sets its status bit at the next clock edge, whatever the enable register holds.
- R4: A strobe at the status address (`STAT_ADDR`, default 0x0A) places the status value on `rd_data` after that edge. At the following edge it clears only the bits that were 1 in that value. A pulse arriving on the strobe edge or later remains set for the next read.
- R5: A write to the status address changes nothing. A write to the enable address (`EN_ADDR`, default 0x09) loads the enable register, and bit 4 of the enable register is always 0.
- R6: A strobe at the enable address returns the enable register on `rd_data` and clears the status register by the same snapshot rule as R4. A strobe at any other address returns 0 and clears nothing.
- R7: In modes 0, 1 and 2, `irq` is high exactly while some status bit and its enable bit are both 1, and it stays high until a read clears them.
- R8: In mode 3 (pen-down), `irq` stays low. Status bits still set and still clear on read, except that the touch bit is not cleared by a read while `pen_present` is high.
- R9: In modes 0 and 1, a read does not clear the data-ready bit; only a `tdata_rd` pulse does. In modes 2 and 3, either a read or a `tdata_rd` pulse clears it.
- R10: If an event for a bit arrives in the same cycle that the bit is being cleared, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_touch | input | 1 | Touch-detected pulse |
| ev_data | input | 1 | Coordinate-data-ready pulse |
| ev_release | input | 1 | Pen-lifted pulse |
| ev_error | input | 1 | Conversion-fault pulse |
| ev_port | input | 3 | Port activity pulses, index = port number |
| mode | input | 2 | 0 timer, 1 host-paced, 2 acquisition, 3 pen-down |
| pen_present | input | 1 | High while the pen touches the panel |
| tdata_rd | input | 1 | Pulse: host has fetched the coordinate data |
| rd_stb | input | 1 | One-cycle read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read result, valid after the strobe edge |
| wr_stb | input | 1 | One-cycle write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| irq | output | 1 | Active-high level interrupt |

## Verification
An event pulse shows in the status one edge after it is sampled, and `irq` follows in the same cycle because it is combinational from the two registers. Read data is due one edge after the strobe, and the clear lands one edge after that. The bench drives every input on the falling edge. Its monitor compares `rd_data` on the falling edge that follows the strobe's rising edge. Each read is followed by an idle cycle, so the next strobe sees the cleared state. `irq` is sampled on falling edges between reads.

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h0A,
  parameter logic [ADDR_W-1:0] EN_ADDR   = 'h09
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_touch,
  input  logic              ev_data,
  input  logic              ev_release,
  input  logic              ev_error,
  input  logic [2:0]        ev_port,
  input  logic [1:0]        mode,
  input  logic              pen_present,
  input  logic              tdata_rd,
  input  logic              rd_stb,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              irq
);
  localparam logic [7:0] LIVE = 8'hEF;

  logic [7:0] stat, ien, snap;
  logic       clr_pend;

  wire [7:0] ev_vec   = {ev_error, ev_release, ev_port[2], 1'b0,
                         ev_port[1], ev_port[0], ev_data, ev_touch};
  wire       hit_stat = rd_stb && (rd_addr == STAT_ADDR);
  wire       hit_en   = rd_stb && (rd_addr == EN_ADDR);
  wire       pen_mode = (mode == 2'd3);
  wire [7:0] keep     = {6'b0, ~mode[1], pen_mode & pen_present};
  wire [7:0] fetch    = {6'b0, tdata_rd, 1'b0};
  wire [7:0] clr_vec  = (clr_pend ? (snap & ~keep) : 8'h00) | fetch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat     <= 8'h00;
      ien      <= 8'h00;
      snap     <= 8'h00;
      clr_pend <= 1'b0;
      rd_data  <= 8'h00;
    end else begin
      stat     <= ((stat & ~clr_vec) | ev_vec) & LIVE;
      clr_pend <= hit_stat | hit_en;
      snap     <= (hit_stat | hit_en) ? stat : 8'h00;
      if (wr_stb && wr_addr == EN_ADDR) ien <= wr_data & LIVE;
      if (rd_stb) rd_data <= hit_stat ? stat : (hit_en ? ien : 8'h00);
    end
  end

  assign irq = (|(stat & ien)) & ~pen_mode;

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hit_stat) |-> (rd_data[4] == 1'b0));

  p_touch_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_touch |=> stat[0]);

  p_fault_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_error |=> stat[7]);

  p_unread_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pend |=> ((stat & $past(stat & ~snap & ~fetch)) == $past(stat & ~snap & ~fetch)));

  p_pen_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pen_mode |-> !irq);

  p_touch_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pend && pen_mode && pen_present && stat[0]) |=> stat[0]);

  p_data_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pend && !mode[1] && !tdata_rd && stat[1]) |=> stat[1]);
endmodule

// File: tb/irq_status_reg_tb_top.sv
module irq_status_reg_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_touch = 0, ev_data = 0, ev_release = 0, ev_error = 0;
  logic [2:0] ev_port = 0;
  logic [1:0] mode = 2'd2;
  logic pen_present = 0, tdata_rd = 0, rd_stb = 0, wr_stb = 0;
  logic [7:0] rd_addr = 0, wr_addr = 0, wr_data = 0, rd_data;
  logic irq;
  int checks = 0, fails = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic pend = 0;

  always #4 clk = ~clk;

  irq_status_reg dut_i (.clk, .rst_n, .ev_touch, .ev_data, .ev_release,
    .ev_error, .ev_port, .mode, .pen_present, .tdata_rd, .rd_stb, .rd_addr,
    .rd_data, .wr_stb, .wr_addr, .wr_data, .irq);

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%h expected=%h", tag, act, exp); end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    rd_stb = 1; rd_addr = a; exp_q.push_back(e); tag_q.push_back(tag);
    tick(); rd_stb = 0; tick();
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_stb = 1; wr_addr = a; wr_data = d; tick(); wr_stb = 0;
  endtask

  task automatic pulse(input logic [7:0] v);
    {ev_error, ev_release, ev_port[2]} = v[7:5];
    {ev_port[1], ev_port[0], ev_data, ev_touch} = v[3:0];
    tick();
    {ev_error, ev_release, ev_touch, ev_data} = 0; ev_port = 0;
  endtask

  always @(posedge clk) pend <= rd_stb;

  always @(negedge clk) if (pend) begin
    logic [7:0] e; string t;
    e = exp_q.pop_front(); t = tag_q.pop_front();
    check(rd_data === e, t, rd_data, e);
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst_n = 1; tick();
    check(irq === 1'b0 && rd_data === 8'h00, "R1 reset outputs", {irq, rd_data}, 0);
    rd(8'h0A, 8'h00, "R1 reset status");
    rd(8'h09, 8'h00, "R1 reset enables");

    pulse(8'h89);
    check(irq === 1'b0, "R3 no irq with enables off", irq, 0);
    rd(8'h0A, 8'h89, "R3 bits set without enable");
    rd(8'h0A, 8'h00, "R4 cleared after read");

    pulse(8'hFF);
    rd(8'h0A, 8'hEF, "R2 layout, bit 4 reads 0");
    rd(8'h0A, 8'h00, "R4 all clear");

    pulse(8'h40);
    wr(8'h0A, 8'h00); tick();
    rd(8'h0A, 8'h40, "R5 status write ignored");
    wr(8'h09, 8'hFF);
    rd(8'h09, 8'hEF, "R5 enable write, bit 4 zero");

    wr(8'h09, 8'h02);
    pulse(8'h02);
    check(irq === 1'b1, "R7 irq on enabled bit", irq, 1);
    rd(8'h0A, 8'h02, "R9 acq mode data read");
    check(irq === 1'b0, "R7 irq drops after clear", irq, 0);
    rd(8'h0A, 8'h00, "R9 acq mode status read clears data");

    mode = 2'd1; wr(8'h09, 8'h04);
    pulse(8'h04);
    repeat (3) tick();
    check(irq === 1'b1, "R7 irq level holds", irq, 1);
    pulse(8'h01);
    check(irq === 1'b1, "R7 unenabled bit keeps level", irq, 1);
    rd(8'h09, 8'h04, "R6 enable read data");
    check(irq === 1'b0, "R6 enable read cleared status", irq, 0);
    rd(8'h0A, 8'h00, "R6 status empty after enable read");
    rd(8'h33, 8'h00, "R6 other address reads 0");

    mode = 2'd2;
    pulse(8'h01);
    rd_stb = 1; rd_addr = 8'h0A; exp_q.push_back(8'h01); tag_q.push_back("R4 snapshot excludes new event");
    ev_port[2] = 1; tick(); rd_stb = 0; ev_port = 0; tick();
    rd(8'h0A, 8'h20, "R4 late event kept pending");

    pulse(8'h80);
    rd_stb = 1; rd_addr = 8'h0A; exp_q.push_back(8'h80); tag_q.push_back("R10 first read");
    tick(); rd_stb = 0; ev_error = 1; tick(); ev_error = 0;
    rd(8'h0A, 8'h80, "R10 set wins over clear");
    rd(8'h0A, 8'h00, "R10 then clears");

    mode = 2'd0;
    pulse(8'h02);
    rd(8'h0A, 8'h02, "R9 timer mode first read");
    rd(8'h0A, 8'h02, "R9 timer mode read does not clear data");
    tdata_rd = 1; tick(); tdata_rd = 0; tick();
    rd(8'h0A, 8'h00, "R9 data fetch clears bit");

    mode = 2'd3; wr(8'h09, 8'hFF); pen_present = 1;
    pulse(8'h81);
    check(irq === 1'b0, "R8 pen-down mode irq low", irq, 0);
    rd(8'h0A, 8'h81, "R8 status still updates");
    rd(8'h0A, 8'h01, "R8 touch held, fault cleared");
    pen_present = 0; tick();
    rd(8'h0A, 8'h01, "R8 touch readable after lift");
    rd(8'h0A, 8'h00, "R8 touch clears after lift");

    repeat (3) tick();
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule